// File: doc/BRIEF.md
# Continued-Fraction Clock Ratio Solver

This block is a sequential engine that finds a small integer pair `fract_o / divide_o` approximating the ratio `num_p / den_q` for a fractional clock divider. `num_p` is the wanted output frequency with any fixed scale factors folded in. `den_q` is the reference frequency with its own scale factors folded in. The numerator is limited to 256 and the denominator to 4096 (both parameters). The engine expands the ratio as a continued fraction and builds convergents from it. It stops when the expansion terminates, which gives an exact ratio. It also stops when the next convergent would exceed either limit, and then keeps the last convergent that still fitted.

Software or a control FSM pulses `start` with both operands present. The engine replies with a one-cycle `done` pulse, and the result fields and the `ok`/`err` flags stay unchanged after that pulse until the next accepted start. Each quotient of the expansion comes from an internal restoring divider that produces one bit per cycle. Degenerate requests (ratio above one, ratio exactly one, zero numerator) are answered without running the divider.

Top module: `cfr_solver`

## Requirements
- R1: When `num_p > den_q` at an accepted start, the result is `err`=1, `ok`=0, `fract_o`=0, `divide_o`=0, with `done` high in the cycle right after the sampling edge.
- R2: When `num_p == den_q` (including both zero), the result is `ok`=1, `fract_o`=1, `divide_o`=1, with `done` high in the cycle right after the sampling edge.
- R3: When `num_p` is 0 and `den_q` is nonzero, the result is `err`=1 with both fields 0, with `done` high in the cycle right after the sampling edge.
- R4: Otherwise the engine repeats these steps: quotient a = q / p, then p becomes q mod p and q becomes the old p. The convergents follow F = a·F' + F'' and D = a·D' + D'', starting from F'=0, D'=1, F''=1, D''=0. When the remainder reaches zero, the final convergent is the result.
- R5: If a new convergent has F > 256 or D > 4096, it is discarded, the previous convergent is the result, and the engine stops.
- R6: If the resulting numerator is 0 (first quotient above 4096), the result is `err`=1 with both fields 0. Any other finished result has `ok`=1.
- R7: `done` is high for exactly one cycle per accepted start, and exactly one of `ok`/`err` is high with it. `fract_o`, `divide_o`, `ok` and `err` hold their values until the next accepted start. After reset all outputs are 0.
- R8: A `start` pulse while `busy` is high is ignored. It neither changes the running result nor produces an extra `done`.
- R9: In the iterative case, `done` rises (W+1)·n clock edges after the sampling edge, where n is the number of quotients computed (including a discarded one) and W is the operand width (33·n by default).
- R10: `busy` is high from the edge after an iterative start until the edge that raises `done`, and is never high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| num_p | input | W (32) | Ratio numerator |
| den_q | input | W (32) | Ratio denominator |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Held: last result valid |
| err | output | 1 | Held: last request rejected or not representable |
| fract_o | output | 9 | Held result numerator (1..256 when ok) |
| divide_o | output | 13 | Held result denominator (1..4096 when ok) |

## Verification
Degenerate requests (R1 to R3) complete in the cycle right after the edge that samples `start`. An iterative request completes 33 edges after that edge for every quotient, so the completion time depends on the length of the expansion. The driver computes the expected pair, flags and quotient count from the requirements. It pushes them into the scoreboard together with the cycle stamp of the sampling edge. The monitor samples on falling edges, and on each `done` it compares the fields, the flags and the elapsed cycle count with the queued entry. A `done` that arrives with an empty queue is reported as a failure, which catches the extra pulse that an ignored mid-run start could cause.

// File: rtl/cfr_pkg.sv
// Package: shared state type for the continued-fraction ratio solver.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package cfr_pkg;
    typedef enum logic {
        CFR_IDLE = 1'b0,
        CFR_RUN  = 1'b1
    } cfr_state_t;
endpackage

// File: rtl/cfr_divider.sv
// Module: cfr_divider
// Restoring unsigned divider with one quotient bit per cycle. A load pulse
// captures the operands; busy stays high for exactly W cycles after it, and
// the quotient and remainder are then held until the next load.
// Assumes: divisor is nonzero whenever load is asserted.
module cfr_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  quo_r;
    logic [W-1:0]  rem_r;
    logic [W-1:0]  dsr_r;
    logic [CW-1:0] cnt_r;
    logic [W:0]    shifted;
    logic          fits;

    // Purpose: form the shifted partial remainder and test it against the divisor.
    always_comb begin
        shifted = {rem_r, quo_r[W-1]};
        fits    = (shifted >= {1'b0, dsr_r});
    end

    // Purpose: load operands or retire one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_r <= '0;
            rem_r <= '0;
            dsr_r <= '0;
            cnt_r <= '0;
        end else if (load) begin
            quo_r <= dividend;
            rem_r <= '0;
            dsr_r <= divisor;
            cnt_r <= CW'(W);
        end else if (cnt_r != '0) begin
            if (fits) begin
                rem_r <= W'(shifted - {1'b0, dsr_r});
                quo_r <= {quo_r[W-2:0], 1'b1};
            end else begin
                rem_r <= shifted[W-1:0];
                quo_r <= {quo_r[W-2:0], 1'b0};
            end
            cnt_r <= cnt_r - 1'b1;
        end
    end

    assign busy      = (cnt_r != '0);
    assign quotient  = quo_r;
    assign remainder = rem_r;
endmodule

// File: rtl/cfr_convergent.sv
// Module: cfr_convergent
// Holds the last two convergents of a continued fraction and forms the next
// one from a quotient with a multiply-accumulate wide enough that the bound
// comparison never sees a wrapped value.
// Assumes: adv is only raised when ovf is low, so stored values stay within
// the limits.
module cfr_convergent #(
    parameter int W         = 32,
    parameter int FRACT_MAX = 256,
    parameter int DIV_MAX   = 4096
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  logic            adv,
    input  logic [W-1:0]    quot,
    output logic [DW-1:0]   cur_f,
    output logic [DW-1:0]   cur_d,
    output logic [DW-1:0]   nxt_f,
    output logic [DW-1:0]   nxt_d,
    output logic            ovf
);
    localparam int DW = $clog2(DIV_MAX + 1);
    localparam int MW = W + DW + 1;

    logic [DW-1:0] f1_r, d1_r, f2_r, d2_r;
    logic [MW-1:0] wide_f, wide_d;

    // Purpose: compute the candidate convergent and check it against the limits.
    always_comb begin
        wide_f = MW'(quot) * MW'(f1_r) + MW'(f2_r);
        wide_d = MW'(quot) * MW'(d1_r) + MW'(d2_r);
        ovf    = (wide_f > MW'(FRACT_MAX)) || (wide_d > MW'(DIV_MAX));
    end

    // Purpose: seed the recurrence or shift in the accepted convergent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f1_r <= '0;
            d1_r <= '0;
            f2_r <= '0;
            d2_r <= '0;
        end else if (init) begin
            f1_r <= DW'(0);
            d1_r <= DW'(1);
            f2_r <= DW'(1);
            d2_r <= DW'(0);
        end else if (adv) begin
            f2_r <= f1_r;
            d2_r <= d1_r;
            f1_r <= wide_f[DW-1:0];
            d1_r <= wide_d[DW-1:0];
        end
    end

    assign cur_f = f1_r;
    assign cur_d = d1_r;
    assign nxt_f = wide_f[DW-1:0];
    assign nxt_d = wide_d[DW-1:0];
endmodule

// File: rtl/cfr_solver.sv
// Module: cfr_solver (top)
// Approximates num_p/den_q by fract_o/divide_o within FRACT_MAX/DIV_MAX
// using a continued-fraction expansion; one-cycle done, held results.
// Assumes: operands are stable in the cycle start is high; start is ignored
// while busy.
module cfr_solver #(
    parameter int W         = 32,
    parameter int FRACT_MAX = 256,
    parameter int DIV_MAX   = 4096,
    localparam int FW       = $clog2(FRACT_MAX + 1),
    localparam int DW       = $clog2(DIV_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  num_p,
    input  logic [W-1:0]  den_q,
    output logic          busy,
    output logic          done,
    output logic          ok,
    output logic          err,
    output logic [FW-1:0] fract_o,
    output logic [DW-1:0] divide_o
);
    import cfr_pkg::*;

    cfr_state_t    state_r;
    logic [W-1:0]  p_r;
    logic          accept, go_iter, step, finish, cont;
    logic          div_load, div_busy;
    logic [W-1:0]  div_dnd, div_dsr, quot, rem;
    logic          conv_adv, ovf;
    logic [DW-1:0] cur_f, cur_d, nxt_f, nxt_d, res_f, res_d;

    // Purpose: decode acceptance, per-quotient update and the finishing condition.
    always_comb begin
        accept  = start && (state_r == CFR_IDLE);
        go_iter = accept && (num_p < den_q) && (num_p != '0);
        step    = (state_r == CFR_RUN) && !div_busy;
        finish  = step && (ovf || (rem == '0));
        cont    = step && !finish;
        res_f   = ovf ? cur_f : nxt_f;
        res_d   = ovf ? cur_d : nxt_d;
    end

    // Purpose: choose divider operands for the first or a following quotient.
    always_comb begin
        div_load = go_iter || cont;
        div_dnd  = go_iter ? den_q : p_r;
        div_dsr  = go_iter ? num_p : rem;
        conv_adv = step && !ovf;
    end

    cfr_divider #(.W(W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (div_load),
        .dividend  (div_dnd),
        .divisor   (div_dsr),
        .busy      (div_busy),
        .quotient  (quot),
        .remainder (rem)
    );

    cfr_convergent #(.W(W), .FRACT_MAX(FRACT_MAX), .DIV_MAX(DIV_MAX)) u_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (go_iter),
        .adv   (conv_adv),
        .quot  (quot),
        .cur_f (cur_f),
        .cur_d (cur_d),
        .nxt_f (nxt_f),
        .nxt_d (nxt_d),
        .ovf   (ovf)
    );

    // Purpose: sequence the engine state and track the current divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_r <= CFR_IDLE;
            p_r     <= '0;
        end else if (go_iter) begin
            state_r <= CFR_RUN;
            p_r     <= num_p;
        end else if (cont) begin
            p_r     <= rem;
        end else if (finish) begin
            state_r <= CFR_IDLE;
        end
    end

    // Purpose: produce the done pulse and the held result and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            ok       <= 1'b0;
            err      <= 1'b0;
            fract_o  <= '0;
            divide_o <= '0;
        end else begin
            done <= 1'b0;
            if (accept && !go_iter) begin
                done <= 1'b1;
                if (num_p == den_q) begin
                    ok       <= 1'b1;
                    err      <= 1'b0;
                    fract_o  <= FW'(1);
                    divide_o <= DW'(1);
                end else begin
                    ok       <= 1'b0;
                    err      <= 1'b1;
                    fract_o  <= '0;
                    divide_o <= '0;
                end
            end else if (finish) begin
                done <= 1'b1;
                if (res_f == '0) begin
                    ok       <= 1'b0;
                    err      <= 1'b1;
                    fract_o  <= '0;
                    divide_o <= '0;
                end else begin
                    ok       <= 1'b1;
                    err      <= 1'b0;
                    fract_o  <= res_f[FW-1:0];
                    divide_o <= res_d;
                end
            end
        end
    end

    assign busy = (state_r == CFR_RUN);
endmodule

// File: rtl/cfr_solver_chk.sv
// Module: cfr_solver_chk
// Property checker for cfr_solver, attached with bind below.
// Assumes: it sees only the top-level ports.
module cfr_solver_chk #(
    parameter int W         = 32,
    parameter int FRACT_MAX = 256,
    parameter int DIV_MAX   = 4096,
    localparam int FW       = $clog2(FRACT_MAX + 1),
    localparam int DW       = $clog2(DIV_MAX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [W-1:0]  num_p,
    input logic [W-1:0]  den_q,
    input logic          busy,
    input logic          done,
    input logic          ok,
    input logic          err,
    input logic [FW-1:0] fract_o,
    input logic [DW-1:0] divide_o
);
    logic unused_ops;
    assign unused_ops = ^{num_p, den_q};

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_flag_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ok ^ err));

    assert_held_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(fract_o) && $stable(divide_o) && $stable(ok) && $stable(err)));

    assert_within_limits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok) |-> (fract_o >= FW'(1) && 32'(fract_o) <= FRACT_MAX && 32'(divide_o) <= DIV_MAX
                          && 32'(fract_o) <= 32'(divide_o)));

    assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (fract_o == '0 && divide_o == '0));

    assert_busy_ends_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind cfr_solver cfr_solver_chk #(.W(W), .FRACT_MAX(FRACT_MAX), .DIV_MAX(DIV_MAX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .num_p    (num_p),
    .den_q    (den_q),
    .busy     (busy),
    .done     (done),
    .ok       (ok),
    .err      (err),
    .fract_o  (fract_o),
    .divide_o (divide_o)
);

// File: tb/cfr_solver_test.sv
// Scoreboard bench for cfr_solver: the driver queues expected results,
// the monitor compares them on each done pulse.
module cfr_solver_test;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  num_p = '0;
    logic [W-1:0]  den_q = '0;
    logic          busy, done, ok, err;
    logic [8:0]    fract_o;
    logic [12:0]   divide_o;

    int      errors = 0;
    int      checks = 0;
    longint  cyc = 0;
    bit      finished = 0;

    typedef struct {
        int     f;
        int     d;
        bit     e;
        longint lat;
        longint sc;
    } exp_t;

    exp_t  sb[$];
    string tags[$];
    int    last_f, last_d;

    cfr_solver uut (
        .clk(clk), .rst_n(rst_n), .start(start), .num_p(num_p), .den_q(den_q),
        .busy(busy), .done(done), .ok(ok), .err(err),
        .fract_o(fract_o), .divide_o(divide_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit cond, input string tag, input longint act, input longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected result from the requirements R1-style rules, written per case.
    function automatic void model(input longint unsigned pi, input longint unsigned qi,
                                  output int ef, output int ed, output bit ee, output int en);
        longint unsigned p = pi, q = qi, a, r, f1, d1, f2, d2, nf, nd;
        en = 0; ef = 0; ed = 0; ee = 0;
        if (p > q) begin ee = 1; return; end           // R1
        if (p == q) begin ef = 1; ed = 1; return; end  // R2
        if (p == 0) begin ee = 1; return; end          // R3
        f1 = 0; d1 = 1; f2 = 1; d2 = 0;                // R4 seeds
        while (p != 0) begin
            a = q / p; r = q - a * p; en++;
            nf = a * f1 + f2; nd = a * d1 + d2;
            if (nf > 256 || nd > 4096) begin           // R5
                ef = int'(f1); ed = int'(d1); break;
            end
            f2 = f1; d2 = d1; f1 = nf; d1 = nd;
            q = p; p = r;
            if (p == 0) begin ef = int'(f1); ed = int'(d1); end
        end
        if (ef == 0) begin ee = 1; ed = 0; end          // R6
    endfunction

    task automatic run(input longint unsigned p, input longint unsigned q, input string tag);
        exp_t e;
        int n;
        @(negedge clk);
        while (busy) @(negedge clk);
        model(p, q, e.f, e.d, e.e, n);
        e.lat = longint'(n) * (W + 1);                  // R9
        e.sc  = cyc + 1;
        sb.push_back(e);
        tags.push_back(tag);
        num_p = W'(p); den_q = W'(q); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    // Monitor: pop and compare on each done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8 unexpected done", 1, 0);
            end else begin
                exp_t e;
                string t;
                e = sb.pop_front();
                t = tags.pop_front();
                check(int'(fract_o) == e.f, {t, " fract"}, fract_o, e.f);
                check(int'(divide_o) == e.d, {t, " divide"}, divide_o, e.d);
                check(err == e.e && ok == !e.e, {t, " flags err"}, err, e.e);
                check((cyc - e.sc) == e.lat, {t, " latency R9"}, cyc - e.sc, e.lat);
                last_f = e.f; last_d = e.d;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 0 && busy == 0 && ok == 0 && err == 0, "R7 reset flags", {done, busy, ok, err}, 0);
        check(fract_o == 0 && divide_o == 0, "R7 reset fields", fract_o, 0);

        run(100, 50, "R1 p>q");
        run(777, 777, "R2 p==q");
        run(0, 0, "R2 both zero");
        run(0, 1000, "R3 zero numerator");
        run(3, 8, "R4 exact 3/8");
        run(12288000, 96000000, "R4 exact audio");
        run(256, 257, "R4 fract at limit");
        run(1, 4096, "R4 divide at limit");
        run(3160320, 96000000, "R5 fallback");
        run(257, 258, "R5 fract over limit");
        run(64'hFFFF_FFFE, 64'hFFFF_FFFF, "R5 wide quotient");
        run(1, 4097, "R6 too low");
        run(1, 5000, "R6 too low far");

        // R7: result held after done while idle
        repeat (6) @(negedge clk);
        check(int'(fract_o) == last_f && int'(divide_o) == last_d && err == 1, "R7 held", fract_o, last_f);

        // R8: start during a run is ignored
        fork
            run(12288000, 96000000, "R8 run with ignored start");
            begin
                repeat (20) @(negedge clk);
                check(busy == 1, "R10 busy mid run", busy, 1);
                num_p = 5; den_q = 1; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        repeat (40) @(negedge clk);
        check(done == 0 && fract_o == 9'd16 && divide_o == 13'd125, "R8 no extra result", fract_o, 16);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule